// File: doc/BRIEF.md
# Speculative Store Queue with Decoupled Writeback

The block keeps every in-flight store of an out-of-order core in program order, from dispatch until the data cache reports the write done. Dispatch takes a free slot and tags it with the store's sequence number. Execution later fills in the address, byte count and data. Commit only marks stores as allowed to write back. A separate drain walk, starting at the oldest slot, sends those stores to the data cache through a fixed number of request ports per cycle.

A store with a byte count of zero leaves the queue without any cache traffic. A conditional store marks itself as allowed to write back as soon as it executes. If the cache refuses a batch of requests, the drain stops until a retry pulse arrives. A squash removes every store younger than a given sequence number and gives its slot back. A completion carries the slot index, and a completion that names a slot with no request outstanding is dropped.

Slots form a ring, so age follows slot position from the head. Completed slots in the middle of the ring are skipped as holes. Sequence numbers are assumed to increase without wrapping, and `DEPTH` must be a power of two.

Top module: `spec_store_queue`

## Requirements
- R1: `alloc_idx` is the next ring slot after the youngest live store, and that slot is not in use. `alloc_ready` is low in each of these cases: all `DEPTH` ring slots are spanned, the number of live stores minus those waiting to write back (eligible, not yet sent) reaches `SPEC_CAP`, or `squash_valid` is high.
- R2: An execute records address, byte count and data for the slot, and the request later carries those values. An execute with `exec_cond` high makes the store eligible with no commit.
- R3: A commit with bound B makes every live store with a sequence number of B or less eligible. Stores with larger numbers stay ineligible and are never requested.
- R4: The drain walk runs from the oldest live store and stops at the first store that is not eligible or not executed. It skips stores already sent. It issues at most `PORTS` requests per cycle: port 0 carries the oldest, port 1 the next oldest, and so on. A sent store is never requested again.
- R5: An eligible, executed store with byte count 0 is freed in the cycle the walk reaches it. It uses no port and never appears on a request.
- R6: If `req_stall` is high while any `req_valid` is high, none of those requests is taken and the queue is blocked. A blocked queue shows no requests. A one-cycle `req_retry` unblocks it from the next cycle, and the refused stores are then requested again.
- R7: A squash with bound N removes every live store with a sequence number greater than N. The next `alloc_idx` is then the slot just after the youngest surviving store.
- R8: A completion for a slot with a request outstanding frees that slot. A completion for a slot that is not live, or whose request has not been sent, is ignored, and that store is still requested later.
- R9: After reset the queue is empty: `alloc_ready` is 1, `alloc_idx` is 0 and no `req_valid` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_valid | input | 1 | Dispatch a store |
| alloc_seq | input | SEQW | Sequence number of the dispatched store |
| alloc_ready | output | 1 | A slot may be taken this cycle |
| alloc_idx | output | IW | Slot given to the dispatched store |
| exec_valid | input | 1 | Store executed |
| exec_idx | input | IW | Slot of the executed store |
| exec_cond | input | 1 | Executed store is a conditional store |
| exec_addr | input | AW | Store address |
| exec_size | input | SZW | Store byte count |
| exec_data | input | DW | Store data |
| commit_valid | input | 1 | Commit step |
| commit_seq | input | SEQW | Youngest committing sequence number |
| squash_valid | input | 1 | Squash |
| squash_seq | input | SEQW | Stores younger than this are removed |
| req_valid | output | PORTS | Per-port cache write request |
| req_idx | output | PORTS*IW | Per-port slot index |
| req_addr | output | PORTS*AW | Per-port address |
| req_size | output | PORTS*SZW | Per-port byte count |
| req_data | output | PORTS*DW | Per-port data |
| req_stall | input | 1 | Cache refuses this cycle's requests |
| req_retry | input | 1 | Cache can take requests again |
| cmp_valid | input | 1 | Write completion |
| cmp_idx | input | IW | Slot of the completed write |

## Verification
The commit bound is swept from "before every store" to "all stores" over three live stores. For each bound the bench checks how many requests appear in the first cycle, how many have appeared in total, and that slots arrive oldest first across both ports, which separates a boundary error in the commit compare from a port-ordering error. A mix of zero-size and sized stores placed across the ring wrap tells a freed zero-size slot from one that is stuck, because a stuck slot would fill the ring during the next allocations. Further runs cover a refusal followed by a retry, a squash followed by re-allocation into the freed slot, an early completion that must be ignored, and a conditional store that writes back with no commit.

// File: rtl/spec_store_queue.sv
module spec_store_queue #(
  parameter int DEPTH    = 8,
  parameter int SPEC_CAP = 6,
  parameter int PORTS    = 2,
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int SEQW     = 16,
  parameter int SZW      = 4,
  localparam int IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_valid,
  input  logic [SEQW-1:0]       alloc_seq,
  output logic                  alloc_ready,
  output logic [IW-1:0]         alloc_idx,
  input  logic                  exec_valid,
  input  logic [IW-1:0]         exec_idx,
  input  logic                  exec_cond,
  input  logic [AW-1:0]         exec_addr,
  input  logic [SZW-1:0]        exec_size,
  input  logic [DW-1:0]         exec_data,
  input  logic                  commit_valid,
  input  logic [SEQW-1:0]       commit_seq,
  input  logic                  squash_valid,
  input  logic [SEQW-1:0]       squash_seq,
  output logic [PORTS-1:0]      req_valid,
  output logic [PORTS*IW-1:0]   req_idx,
  output logic [PORTS*AW-1:0]   req_addr,
  output logic [PORTS*SZW-1:0]  req_size,
  output logic [PORTS*DW-1:0]   req_data,
  input  logic                  req_stall,
  input  logic                  req_retry,
  input  logic                  cmp_valid,
  input  logic [IW-1:0]         cmp_idx
);

  logic [SEQW-1:0] seq_q  [DEPTH];
  logic [AW-1:0]   addr_q [DEPTH];
  logic [SZW-1:0]  size_q [DEPTH];
  logic [DW-1:0]   data_q [DEPTH];

  logic [DEPTH-1:0] valid, elig, sent, exe_f;
  logic [DEPTH-1:0] n_valid, n_elig, n_sent, n_exe;
  logic [DEPTH-1:0] grant, zdone;
  logic [IW:0]      head, tail, n_head, n_tail, span;
  logic             blocked;
  logic             fire;
  logic             alloc_fire;
  int               nvalid, npend;

  assign span       = tail - head;
  assign nvalid     = $countones(valid);
  assign npend      = $countones(valid & elig & ~sent);
  assign alloc_ready = !squash_valid && (span < (IW+1)'(DEPTH)) && ((nvalid - npend) < SPEC_CAP);
  assign alloc_idx  = tail[IW-1:0];
  assign alloc_fire = alloc_valid && alloc_ready;
  assign fire       = (|req_valid) && !req_stall;

  always_comb begin : walk
    int used;
    logic stop;
    logic [IW-1:0] pos;
    grant     = '0;
    zdone     = '0;
    req_valid = '0;
    req_idx   = '0;
    req_addr  = '0;
    req_size  = '0;
    req_data  = '0;
    used      = 0;
    stop      = blocked;
    for (int r = 0; r < DEPTH; r++) begin
      pos = head[IW-1:0] + IW'(r);
      if (!stop && ((IW+1)'(r) < span) && valid[pos]) begin
        if (!elig[pos]) stop = 1'b1;
        else if (sent[pos]) stop = stop;
        else if (!exe_f[pos]) stop = 1'b1;
        else if (size_q[pos] == '0) zdone[pos] = 1'b1;
        else if (used < PORTS) begin
          grant[pos]                  = 1'b1;
          req_valid[used]             = 1'b1;
          req_idx[used*IW +: IW]      = pos;
          req_addr[used*AW +: AW]     = addr_q[pos];
          req_size[used*SZW +: SZW]   = size_q[pos];
          req_data[used*DW +: DW]     = data_q[pos];
          used++;
        end else stop = 1'b1;
      end
    end
  end

  always_comb begin : next_state
    logic [IW:0]   keep;
    logic [IW:0]   nspan;
    logic          found;
    logic [IW-1:0] pos;
    n_valid = valid;
    n_elig  = elig;
    n_sent  = sent;
    n_exe   = exe_f;
    n_tail  = tail;
    keep    = '0;
    if (exec_valid && valid[exec_idx]) begin
      n_exe[exec_idx] = 1'b1;
      if (exec_cond) n_elig[exec_idx] = 1'b1;
    end
    if (commit_valid)
      for (int i = 0; i < DEPTH; i++)
        if (valid[i] && seq_q[i] <= commit_seq) n_elig[i] = 1'b1;
    if (fire) n_sent = n_sent | grant;
    n_valid = n_valid & ~zdone;
    if (cmp_valid && valid[cmp_idx] && sent[cmp_idx]) n_valid[cmp_idx] = 1'b0;
    if (squash_valid) begin
      for (int r = 0; r < DEPTH; r++) begin
        pos = head[IW-1:0] + IW'(r);
        if (((IW+1)'(r) < span) && valid[pos] && seq_q[pos] <= squash_seq)
          keep = (IW+1)'(r + 1);
      end
      for (int i = 0; i < DEPTH; i++)
        if (valid[i] && seq_q[i] > squash_seq) n_valid[i] = 1'b0;
      n_tail = head + keep;
    end
    if (alloc_fire) begin
      n_valid[tail[IW-1:0]] = 1'b1;
      n_elig[tail[IW-1:0]]  = 1'b0;
      n_sent[tail[IW-1:0]]  = 1'b0;
      n_exe[tail[IW-1:0]]   = 1'b0;
      n_tail = tail + 1'b1;
    end
    nspan  = n_tail - head;
    n_head = n_tail;
    found  = 1'b0;
    for (int r = 0; r < DEPTH; r++) begin
      pos = head[IW-1:0] + IW'(r);
      if (!found && ((IW+1)'(r) < nspan) && n_valid[pos]) begin
        n_head = head + (IW+1)'(r);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= '0;
      elig    <= '0;
      sent    <= '0;
      exe_f   <= '0;
      head    <= '0;
      tail    <= '0;
      blocked <= 1'b0;
    end else begin
      valid <= n_valid;
      elig  <= n_elig;
      sent  <= n_sent;
      exe_f <= n_exe;
      head  <= n_head;
      tail  <= n_tail;
      if ((|req_valid) && req_stall) blocked <= 1'b1;
      else if (req_retry)            blocked <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) seq_q[tail[IW-1:0]] <= alloc_seq;
    if (exec_valid && valid[exec_idx]) begin
      addr_q[exec_idx] <= exec_addr;
      size_q[exec_idx] <= exec_size;
      data_q[exec_idx] <= exec_data;
    end
  end

  assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !valid[alloc_idx]);

  assert_refusal_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_valid) && req_stall) |=> (req_valid == '0));

  assert_no_reissue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && !req_stall) |=> !(req_valid[0] && req_idx[IW-1:0] == $past(req_idx[IW-1:0])));

  for (genvar p = 0; p < PORTS; p++) begin : g_port_chk
    logic [IW-1:0] ri;
    assign ri = req_idx[p*IW +: IW];
    assert_issue_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[p] |-> (valid[ri] && elig[ri] && !sent[ri] && exe_f[ri]));
    assert_nonzero_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[p] |-> (req_size[p*SZW +: SZW] != '0));
  end

endmodule

// File: tb/tb_spec_store_queue.sv
module tb_spec_store_queue;
  localparam int DEPTH = 4, SPEC_CAP = 3, PORTS = 2, AW = 16, DW = 16, SEQW = 8, SZW = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic alloc_valid = 0, exec_valid = 0, exec_cond = 0, commit_valid = 0, squash_valid = 0;
  logic req_stall = 0, req_retry = 0, cmp_valid = 0;
  logic [SEQW-1:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [IW-1:0] exec_idx = 0, cmp_idx = 0;
  logic [AW-1:0] exec_addr = 0;
  logic [SZW-1:0] exec_size = 0;
  logic [DW-1:0] exec_data = 0;
  logic alloc_ready;
  logic [IW-1:0] alloc_idx;
  logic [PORTS-1:0] req_valid;
  logic [PORTS*IW-1:0] req_idx;
  logic [PORTS*AW-1:0] req_addr;
  logic [PORTS*SZW-1:0] req_size;
  logic [PORTS*DW-1:0] req_data;

  spec_store_queue #(.DEPTH(DEPTH), .SPEC_CAP(SPEC_CAP), .PORTS(PORTS), .AW(AW), .DW(DW),
                     .SEQW(SEQW), .SZW(SZW)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx), .exec_valid(exec_valid),
    .exec_idx(exec_idx), .exec_cond(exec_cond), .exec_addr(exec_addr), .exec_size(exec_size),
    .exec_data(exec_data), .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .req_valid(req_valid),
    .req_idx(req_idx), .req_addr(req_addr), .req_size(req_size), .req_data(req_data),
    .req_stall(req_stall), .req_retry(req_retry), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx));

  int nchk = 0, nfail = 0, nx = 0, ng = 0;
  int got [8];

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_alloc(input int seq, output int idx);
    alloc_valid = 1; alloc_seq = SEQW'(seq); #1;
    chk("R1 alloc ready", alloc_ready, 1);
    chk("R1 alloc index", alloc_idx, nx);
    idx = alloc_idx; nx = (nx + 1) % DEPTH;
    tick(); alloc_valid = 0;
  endtask

  task automatic do_exec(input int idx, input int addr, input int size, input int data, input bit cond);
    exec_valid = 1; exec_idx = IW'(idx); exec_addr = AW'(addr); exec_size = SZW'(size);
    exec_data = DW'(data); exec_cond = cond;
    tick(); exec_valid = 0; exec_cond = 0;
  endtask

  task automatic do_commit(input int seq);
    commit_valid = 1; commit_seq = SEQW'(seq); tick(); commit_valid = 0;
  endtask

  task automatic do_cmp(input int idx);
    cmp_valid = 1; cmp_idx = IW'(idx); tick(); cmp_valid = 0;
  endtask

  task automatic sample_tick();
    #1;
    for (int p = 0; p < PORTS; p++)
      if (req_valid[p]) begin got[ng] = int'(req_idx[p*IW +: IW]); ng++; end
    tick();
  endtask

  initial begin
    #(20 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int a0, a1, a2, t;
    repeat (3) @(posedge clk);
    #1; rst_n = 1; #1;
    chk("R9 reset ready", alloc_ready, 1);
    chk("R9 reset index", alloc_idx, 0);
    chk("R9 reset no request", req_valid, 0);

    do_alloc(10, a0); do_alloc(11, a1); do_alloc(12, a2);
    #1; chk("R1 speculative cap reached", alloc_ready, 0);
    do_exec(0, 100, 4, 16'h1111, 0); do_exec(1, 101, 4, 16'h2222, 0); do_exec(2, 102, 4, 16'h3333, 0);
    #1; chk("R3 nothing eligible before commit", req_valid, 0);
    do_commit(10);
    #1;
    chk("R3 bound 10 one request", req_valid, 1);
    chk("R4 oldest on port 0", req_idx[IW-1:0], 0);
    chk("R1 pending frees cap", alloc_ready, 1);
    req_stall = 1; tick(); req_stall = 0; #1;
    chk("R6 blocked after refusal", req_valid, 0);
    tick(); chk("R6 still blocked", req_valid, 0);
    req_retry = 1; #1; chk("R6 blocked during retry cycle", req_valid, 0);
    tick(); req_retry = 0; #1;
    chk("R6 reissue after retry", req_valid, 1);
    chk("R6 reissue index", req_idx[IW-1:0], 0);
    chk("R2 request address", req_addr[AW-1:0], 100);
    tick();
    chk("R4 sent not requested again", req_valid, 0);
    do_commit(12);
    #1;
    chk("R4 two ports used", req_valid, 3);
    chk("R4 port 0 index", req_idx[IW-1:0], 1);
    chk("R4 port 1 index", req_idx[2*IW-1:IW], 2);
    chk("R2 port 1 address", req_addr[2*AW-1:AW], 102);
    chk("R2 port 1 data", req_data[2*DW-1:DW], 16'h3333);
    tick();
    chk("R4 drained", req_valid, 0);
    chk("R1 sent stores still occupy cap", alloc_ready, 0);
    do_cmp(1); #1;
    chk("R8 completion frees slot", alloc_ready, 1);
    do_cmp(0); do_cmp(2); #1;
    chk("R8 ring empty index", alloc_idx, 3);

    do_alloc(20, a0); do_alloc(21, a1); do_alloc(22, a2);
    do_exec(a0, 200, 0, 0, 0); do_exec(a1, 210, 2, 16'h00AB, 0); do_exec(a2, 220, 0, 0, 0);
    do_cmp(a1);
    do_commit(22);
    #1;
    chk("R5 only sized store requested", req_valid, 1);
    chk("R8 early completion ignored", req_idx[IW-1:0], a1);
    chk("R5 size carried", req_size[SZW-1:0], 2);
    tick();
    chk("R5 zero size never requested", req_valid, 0);
    do_cmp(a1);

    alloc_valid = 1; alloc_seq = 30; #1;
    tick(); alloc_valid = 0; a0 = 2; nx = 3;
    do_alloc(31, a1); do_alloc(32, a2);
    chk("R5 zero size slots freed", nx, 1);
    squash_valid = 1; squash_seq = 30; #1;
    chk("R1 no alloc during squash", alloc_ready, 0);
    tick(); squash_valid = 0; #1;
    chk("R7 tail retracted", alloc_idx, 3);
    nx = 3;
    do_exec(a0, 300, 1, 16'h0300, 0);
    do_alloc(40, a1);
    do_exec(a1, 301, 1, 16'h0301, 0);
    do_commit(40);
    #1;
    chk("R7 survivor and new store requested", req_valid, 3);
    chk("R7 port 0 survivor", req_idx[IW-1:0], 2);
    chk("R7 port 1 reused slot", req_idx[2*IW-1:IW], 3);
    chk("R7 reused slot address", req_addr[2*AW-1:AW], 301);
    tick();
    do_cmp(2); do_cmp(3);

    do_alloc(50, a0);
    do_exec(a0, 500, 4, 16'h5050, 1);
    #1;
    chk("R2 conditional eligible at execute", req_valid, 1);
    chk("R2 conditional data", req_data[DW-1:0], 16'h5050);
    tick();
    do_cmp(a0);

    for (int b = 0; b < 4; b++) begin
      int base;
      int ix [3];
      base = 60 + 10 * b;
      for (int i = 0; i < 3; i++) do_alloc(base + i, ix[i]);
      for (int i = 0; i < 3; i++) do_exec(ix[i], 1000 + 100 * b + i, 2, b * 16 + i, 0);
      do_commit(base + b - 1);
      #1;
      t = (b > PORTS) ? PORTS : b;
      chk("R3 first cycle request count", $countones(req_valid), t);
      ng = 0;
      repeat (2) sample_tick();
      chk("R3 requests up to bound", ng, b);
      do_commit(base + 2);
      repeat (3) sample_tick();
      chk("R4 all drained", ng, 3);
      for (int i = 0; i < 3; i++) chk("R4 oldest first order", got[i], ix[i]);
      for (int i = 0; i < 3; i++) do_cmp(ix[i]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule